// File: doc/BRIEF.md
# Page Access-Control Checker

This block sits beside the address translation path of a memory management unit and judges each memory access against the access-control code of the page descriptor that translation selected. From the kind of access and that 3-bit code, plus the separate page-length check result, it decides in the same cycle whether the access goes ahead, is aborted, or goes ahead with a management trap. It also emits set strobes for the descriptor's accessed and written bits.

The block owns the management status flags: three abort-reason flags, a trap flag and a trap-enable control. Software can write these flags through a simple write strobe. Any abort flag that is set freezes the flags against further hardware updates. A qualifying trap reaches the instruction sequencer as a registered one-cycle request. An instruction that switches trap-enable off still gets its own trap, because the enable is remembered until the next instruction boundary.

Top module: `mmu_acf_check`

## Requirements
- R1: An access aborts when the code is 000, 011 or 111 (any kind), when the code is 001 or 010 and the kind is write or read-modify-write, or when `len_fail` is high. Kind encodings: 00 read, 01 write, 10 read-modify-write, 11 treated as read-modify-write.
- R2: Code 001 meets the trap condition on read accesses only.
- R3: Code 100 meets the trap condition on every kind. Code 101 meets it on write and read-modify-write only. Codes 110 and 010 never meet it.
- R4: `set_a` is high only for a valid, non-aborted access whose code meets the trap condition. `trap_cond` marks the same case.
- R5: `set_w` is high for a valid, non-aborted write or read-modify-write access.
- R6: On a valid access, while no abort flag is set, the next clock sets status bit 15 for codes 000/011/111, bit 14 for `len_fail`, and bit 13 for a write-type access under code 001/010.
- R7: Status bit 12 (trap flag) is set the cycle after a non-aborted access that meets the trap condition. An aborted access leaves it unchanged.
- R8: While any of status bits 15..13 is set, accesses change no status bit. A software write with bit 15 set produces this frozen state.
- R9: `trap_req` is high for exactly the one cycle after a non-aborted, trap-condition access, and only when trap-enable (status bit 9) is set.
- R10: If trap-enable is cleared by software after `instr_start`, a trap-condition access before the next `instr_start` still raises `trap_req`.
- R11: After reset, `sr_q` is 0 and `trap_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| acc_kind | input | 2 | Access kind: 00 read, 01 write, 10/11 read-modify-write |
| acf | input | 3 | Page access-control code |
| len_fail | input | 1 | Page-length check failed |
| instr_start | input | 1 | First cycle of a new instruction |
| sr_wr_en | input | 1 | Software write strobe for status flags |
| sr_wr_data | input | 16 | Write data (bits 15..12 and 9 used) |
| abort_o | output | 1 | Access aborted |
| trap_cond | output | 1 | Access allowed with trap condition |
| set_a | output | 1 | Set descriptor accessed bit |
| set_w | output | 1 | Set descriptor written bit |
| trap_req | output | 1 | One-cycle trap request to sequencer |
| sr_q | output | 16 | Status flags (15..13 abort, 12 trap, 9 enable) |

## Verification
All eight codes are crossed with all four access kinds. This separates the abort rule from the trap rule for every code, and the read-only trap of 001 from the write-only trap of 101. Length failures on an otherwise open page show that a length abort suppresses the trap flag and sets only its own flag. Frozen-state runs show that hardware updates stop. Sequences that clear trap-enable before and after an instruction boundary show that the enable is remembered for the current instruction only.

// File: rtl/mmu_acf_check.sv
module mmu_acf_check (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  acc_kind,
  input  logic [2:0]  acf,
  input  logic        len_fail,
  input  logic        instr_start,
  input  logic        sr_wr_en,
  input  logic [15:0] sr_wr_data,
  output logic        abort_o,
  output logic        trap_cond,
  output logic        set_a,
  output logic        set_w,
  output logic        trap_req,
  output logic [15:0] sr_q
);

  logic [2:0] flg_abt;
  logic       flg_trp;
  logic       te;
  logic       te_held;
  logic       trq_q;

  wire is_rd    = (acc_kind == 2'b00);
  wire is_wr    = ~is_rd;
  wire nonres   = (acf == 3'b000) | (acf == 3'b011) | (acf == 3'b111);
  wire ro_viol  = ((acf == 3'b001) | (acf == 3'b010)) & is_wr;
  wire tc_hit   = ((acf == 3'b001) & is_rd) | (acf == 3'b100) | ((acf == 3'b101) & is_wr);
  wire frozen   = |flg_abt;
  wire abt      = nonres | ro_viol | len_fail;
  wire ok       = req_valid & ~abt;
  wire te_eff   = te | te_held;

  assign abort_o   = req_valid & abt;
  assign trap_cond = ok & tc_hit;
  assign set_a     = ok & tc_hit;
  assign set_w     = ok & is_wr;
  assign trap_req  = trq_q;
  assign sr_q      = {flg_abt, flg_trp, 2'b00, te, 9'b0};

  wire unused_ok = ^{sr_wr_data[11:10], sr_wr_data[8:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg_abt <= 3'b000;
      flg_trp <= 1'b0;
      te      <= 1'b0;
    end else if (sr_wr_en) begin
      flg_abt <= sr_wr_data[15:13];
      flg_trp <= sr_wr_data[12];
      te      <= sr_wr_data[9];
    end else if (req_valid && !frozen) begin
      flg_abt <= flg_abt | {nonres, len_fail, ro_viol};
      if (ok && tc_hit) flg_trp <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      te_held <= 1'b0;
    end else if (sr_wr_en && te && !sr_wr_data[9]) begin
      te_held <= 1'b1;
    end else if (instr_start) begin
      te_held <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trq_q <= 1'b0;
    else        trq_q <= ok & tc_hit & te_eff;
  end

  // R8
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|sr_q[15:13] && !sr_wr_en) |=> $stable(sr_q[15:12]));

  // R7
  abort_keeps_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_o && !sr_wr_en) |=> $stable(sr_q[12]));

  // R9
  trap_req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(trap_cond));

  // R3
  open_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acf == 3'b110 && !len_fail) |-> (!abort_o && !trap_cond));

  // R7
  trap_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_q[12]) |-> $past(trap_cond || sr_wr_en));

  // R4
  a_vs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_a && abort_o));

endmodule

// File: tb/sim_mmu_acf_check.sv
module sim_mmu_acf_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  acc_kind = 2'b00;
  logic [2:0]  acf = 3'b000;
  logic        len_fail = 1'b0;
  logic        instr_start = 1'b0;
  logic        sr_wr_en = 1'b0;
  logic [15:0] sr_wr_data = 16'h0;
  logic        abort_o, trap_cond, set_a, set_w, trap_req;
  logic [15:0] sr_q;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mmu_acf_check u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_kind(acc_kind),
    .acf(acf), .len_fail(len_fail), .instr_start(instr_start),
    .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .abort_o(abort_o),
    .trap_cond(trap_cond), .set_a(set_a), .set_w(set_w),
    .trap_req(trap_req), .sr_q(sr_q)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic m_abort(input logic [1:0] k, input logic [2:0] c, input logic lf);
    logic w = (k != 2'b00);
    return lf || c == 3'b000 || c == 3'b011 || c == 3'b111 || ((c == 3'b001 || c == 3'b010) && w);
  endfunction

  function automatic logic m_tc(input logic [1:0] k, input logic [2:0] c);
    logic w = (k != 2'b00);
    return (c == 3'b001 && !w) || c == 3'b100 || (c == 3'b101 && w);
  endfunction

  task automatic sw_write(input logic [15:0] d);
    @(negedge clk);
    sr_wr_en = 1'b1; sr_wr_data = d;
    @(negedge clk);
    sr_wr_en = 1'b0;
  endtask

  task automatic mark_instr;
    @(negedge clk);
    instr_start = 1'b1;
    @(negedge clk);
    instr_start = 1'b0;
  endtask

  task automatic access(input logic [1:0] k, input logic [2:0] c, input logic lf);
    @(negedge clk);
    req_valid = 1'b1; acc_kind = k; acf = c; len_fail = lf;
    #1;
    @(negedge clk);
    req_valid = 1'b0; len_fail = 1'b0;
  endtask

  task automatic t_reset;
    check("R11 sr_q", sr_q, 16'h0000);
    check("R11 trap_req", {15'b0, trap_req}, 16'h0);
  endtask

  task automatic t_sweep;
    sw_write(16'h8000);
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 4; k++) begin
        logic ea, et;
        @(negedge clk);
        req_valid = 1'b1; acc_kind = k[1:0]; acf = c[2:0]; len_fail = 1'b0;
        #1;
        ea = m_abort(k[1:0], c[2:0], 1'b0);
        et = m_tc(k[1:0], c[2:0]) && !ea;
        check("R1 abort", {15'b0, abort_o}, {15'b0, ea});
        check("R2/R3 trap_cond", {15'b0, trap_cond}, {15'b0, et});
        check("R4 set_a", {15'b0, set_a}, {15'b0, et});
        check("R5 set_w", {15'b0, set_w}, {15'b0, !ea && k != 0});
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 frozen after sweep", sr_q, 16'h8000);
    sw_write(16'h0000);
  endtask

  task automatic t_flags;
    access(2'b00, 3'b000, 1'b0);
    check("R6 nonres flag", sr_q, 16'h8000);
    sw_write(16'h0000);
    access(2'b01, 3'b010, 1'b0);
    check("R6 ro flag", sr_q, 16'h2000);
    sw_write(16'h0000);
    access(2'b00, 3'b110, 1'b1);
    check("R6 len flag", sr_q, 16'h4000);
    sw_write(16'h0000);
  endtask

  task automatic t_trap_flag;
    access(2'b00, 3'b100, 1'b0);
    check("R7 trap flag set", sr_q, 16'h1000);
    check("R9 no req when disabled", {15'b0, trap_req}, 16'h0);
    sw_write(16'h0000);
    access(2'b01, 3'b101, 1'b1);
    check("R7 aborted access leaves trap flag", sr_q & 16'h1000, 16'h0000);
    sw_write(16'h0000);
    access(2'b00, 3'b110, 1'b0);
    check("R3 code 110 no trap flag", sr_q, 16'h0000);
  endtask

  task automatic t_freeze;
    sw_write(16'h8000);
    access(2'b01, 3'b001, 1'b0);
    check("R8 abort during freeze", sr_q, 16'h8000);
    access(2'b00, 3'b100, 1'b0);
    check("R8 trap during freeze", sr_q, 16'h8000);
    sw_write(16'h0000);
  endtask

  task automatic t_trap_req;
    sw_write(16'h0200);
    access(2'b10, 3'b101, 1'b0);
    check("R9 trap_req pulse", {15'b0, trap_req}, 16'h1);
    check("R7 trap flag with enable", sr_q, 16'h1200);
    @(negedge clk);
    check("R9 trap_req one cycle", {15'b0, trap_req}, 16'h0);
    access(2'b00, 3'b101, 1'b0);
    check("R9 no req without condition", {15'b0, trap_req}, 16'h0);
  endtask

  task automatic t_te_clear;
    sw_write(16'h0200);
    mark_instr();
    sw_write(16'h0000);
    access(2'b00, 3'b100, 1'b0);
    check("R10 trap after te clear", {15'b0, trap_req}, 16'h1);
    mark_instr();
    access(2'b00, 3'b100, 1'b0);
    check("R10 no trap next instr", {15'b0, trap_req}, 16'h0);
    sw_write(16'h0000);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sweep();
    t_flags();
    t_trap_flag();
    t_freeze();
    t_trap_req();
    t_te_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule